// File: doc/BRIEF.md
# Serial GPIO Expander Controller

This block widens the GPIO count of a chip by driving a chain of external shift registers over four pins: a serial clock, a serial data output, a serial data input and a latch strobe. It scans a frame over and over. The frame visits every enabled port, from 0 to 31, and shifts 1 to 4 bits for each one. Output bits come from an output holding bank. Input bits are gathered into an input holding bank.

The host configures and observes the block through a simple word-addressed register port. Writes take effect on the clock edge, and reads are combinational. The host sets the bits-per-port count, the clock divider, the port enable mask, and the per-bit interrupt enables. It can also read and clear the per-bit change flags. A single level-high interrupt line reports any flagged input bit whose enable is set.

A bit in either bank is addressed by its bit index (one register per index) and its port (the bit position inside that register). Register map (word addresses): 0 CFG (bits [1:0] = bits-per-port minus 1), 1 DIV (bits [15:0]), 2 PORT_EN (bit p enables port p), 4+b OUT bank index b, 8+b IN bank index b (read-only), 12+b IE index b, 16+b FLAG index b (write 1 to clear).

Top module: `sio_expander`

## Requirements
- R1: After reset, ser_clk, ser_dout, ser_load and irq are 0. DIV reads 2, and CFG, PORT_EN, OUT, IN, IE and FLAG registers read 0.
- R2: Within a frame, bits are sent in ascending order of enabled port. Inside a port they go from index 0 upward. Each bit is the OUT bank value at (index, port), and it is valid while ser_clk is high.
- R3: A frame has exactly (number of enabled ports) x (bits per port) rising edges of ser_clk. Disabled ports send no bits.
- R4: Each half-period of ser_clk lasts DIV system clocks. A DIV of 0 behaves as 1.
- R5: After the last bit of a frame, ser_load is high for 2 x DIV system clocks while ser_clk is low. The next frame begins when it drops.
- R6: The OUT bank is sampled at the start of each frame. A write made while a frame is shifting shows up only in the following frame.
- R7: ser_din is sampled on each ser_clk rising edge into bit (index, port) of that frame. The IN bank changes only at the end of the latch strobe, when all of its bits update together. Bits not shifted in that frame read 0.
- R8: A FLAG bit is set when a newly latched IN bit differs from its previous value. It stays set until the host writes a 1 to it, and writing 0 leaves it unchanged. irq is high exactly when some FLAG bit and its IE bit are both 1.
- R9: With PORT_EN zero, the block is idle: it makes no ser_clk edges and holds ser_load and ser_dout at 0. Clearing PORT_EN mid-frame lets the current frame complete first.
- R10: CFG bits [1:0] select 1 to 4 bits per port (field value plus 1). PORT_EN, CFG and DIV are sampled at frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 5 | Register word address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational) |
| ser_clk | output | 1 | Serial clock to the shift-register chain |
| ser_dout | output | 1 | Serial data toward the output chain |
| ser_load | output | 1 | Latch strobe closing each frame |
| ser_din | input | 1 | Serial data from the input chain |
| irq | output | 1 | Level-high interrupt |

## Verification
A wrong port or bit counter shows up at the very next ser_clk rising edge as a misplaced data bit. At the end of that frame it also shows up as a wrong edge count before ser_load. A faulty divider stretches or shortens the first high phase after the snapshot. A broken capture path or holding update becomes visible in the IN bank and the FLAG bits one latch strobe after the bad frame. irq follows the FLAG state within the same cycle.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SHIFT = 2'd1,
        SEQ_LOAD  = 2'd2
    } seq_st_e;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] REG_CFG  = 5'd0;
    localparam logic [ADDR_W-1:0] REG_DIV  = 5'd1;
    localparam logic [ADDR_W-1:0] REG_PEN  = 5'd2;
    localparam logic [ADDR_W-1:0] REG_OUT0 = 5'd4;
    localparam logic [ADDR_W-1:0] REG_IN0  = 5'd8;
    localparam logic [ADDR_W-1:0] REG_IE0  = 5'd12;
    localparam logic [ADDR_W-1:0] REG_FLG0 = 5'd16;

endpackage

// File: rtl/sio_clkdiv.sv
`timescale 1ns/1ps
module sio_clkdiv #(
    parameter int DIVW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div_val,
    output logic            tick
);

    typedef struct packed {
        logic [DIVW-1:0] cnt;
    } div_state_t;

    div_state_t      s_d, s_q;
    logic [DIVW-1:0] div_eff;

    always_comb begin
        div_eff = (div_val == '0) ? {{(DIVW-1){1'b0}}, 1'b1} : div_val;
        s_d     = s_q;
        tick    = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
        end else if (s_q.cnt >= div_eff - 1'b1) begin
            s_d.cnt = '0;
            tick    = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (s_q.cnt < div_eff)) else $error("divider count out of range"); // R4

endmodule

// File: rtl/sio_frame_seq.sv
`timescale 1ns/1ps
module sio_frame_seq
    import sio_pkg::*;
#(
    parameter int NPORT = 32,
    parameter int MAXB  = 4,
    parameter int DIVW  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [NPORT-1:0]         port_en,
    input  logic [$clog2(MAXB)-1:0]  bpp_m1,
    input  logic [DIVW-1:0]          div_cfg,
    input  logic [NPORT*MAXB-1:0]    out_bank,
    input  logic                     sdin,
    output logic                     run,
    output logic [DIVW-1:0]          div_use,
    output logic                     sclk,
    output logic                     sdout,
    output logic                     sload,
    output logic                     commit,
    output logic [NPORT*MAXB-1:0]    cap_data
);

    localparam int PW = $clog2(NPORT);
    localparam int BW = $clog2(MAXB);
    localparam int NB = NPORT * MAXB;

    typedef struct packed {
        seq_st_e         st;
        logic            phase;
        logic [PW-1:0]   port;
        logic [BW-1:0]   bidx;
        logic [NPORT-1:0] en;
        logic [BW-1:0]   bpp;
        logic [DIVW-1:0] div;
        logic [NB-1:0]   osnap;
        logic [NB-1:0]   shadow;
    } seq_t;

    seq_t         s_d, s_q;
    logic         start;
    logic [PW:0]  first_en;
    logic [PW:0]  next_en;
    int           cur_idx;

    function automatic logic [PW:0] lowest_from(input logic [NPORT-1:0] m, input int from);
        logic [PW:0] r;
        r = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (m[i] && (i >= from)) r = {1'b1, PW'(i)};
        end
        return r;
    endfunction

    always_comb begin
        s_d      = s_q;
        start    = 1'b0;
        commit   = 1'b0;
        cur_idx  = int'(s_q.bidx) * NPORT + int'(s_q.port);
        first_en = lowest_from(port_en, 0);
        next_en  = lowest_from(s_q.en, int'(s_q.port) + 1);

        case (s_q.st)
            SEQ_IDLE: begin
                start = |port_en;
            end
            SEQ_SHIFT: begin
                if (tick) begin
                    if (!s_q.phase) begin
                        s_d.phase           = 1'b1;
                        s_d.shadow[cur_idx] = sdin;
                    end else begin
                        s_d.phase = 1'b0;
                        if (s_q.bidx == s_q.bpp) begin
                            s_d.bidx = '0;
                            if (next_en[PW]) s_d.port = next_en[PW-1:0];
                            else             s_d.st   = SEQ_LOAD;
                        end else begin
                            s_d.bidx = s_q.bidx + 1'b1;
                        end
                    end
                end
            end
            SEQ_LOAD: begin
                if (tick) begin
                    if (!s_q.phase) begin
                        s_d.phase = 1'b1;
                    end else begin
                        commit    = 1'b1;
                        s_d.phase = 1'b0;
                        if (|port_en) start = 1'b1;
                        else          s_d.st = SEQ_IDLE;
                    end
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase

        if (start) begin
            s_d.st     = SEQ_SHIFT;
            s_d.phase  = 1'b0;
            s_d.port   = first_en[PW-1:0];
            s_d.bidx   = '0;
            s_d.en     = port_en;
            s_d.bpp    = bpp_m1;
            s_d.div    = div_cfg;
            s_d.osnap  = out_bank;
            s_d.shadow = '0;
        end

        run      = (s_q.st != SEQ_IDLE);
        div_use  = s_q.div;
        sclk     = (s_q.st == SEQ_SHIFT) && s_q.phase;
        sload    = (s_q.st == SEQ_LOAD);
        sdout    = (s_q.st == SEQ_SHIFT) && s_q.osnap[cur_idx];
        cap_data = s_q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_PORT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_SHIFT) |-> s_q.en[s_q.port]) else $error("shifting a disabled port"); // R3

    AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_SHIFT) |-> (s_q.bidx <= s_q.bpp)) else $error("bit index past count"); // R10

    AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st != SEQ_IDLE) && !tick) |=> $stable(s_q.phase)) else $error("phase moved without tick"); // R4

endmodule

// File: rtl/sio_host_regs.sv
`timescale 1ns/1ps
module sio_host_regs
    import sio_pkg::*;
#(
    parameter int NPORT   = 32,
    parameter int MAXB    = 4,
    parameter int DIVW    = 16,
    parameter int DIV_RST = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic [DATA_W-1:0]        host_rdata,
    input  logic                     commit,
    input  logic [NPORT*MAXB-1:0]    cap_data,
    output logic [$clog2(MAXB)-1:0]  bpp_m1,
    output logic [DIVW-1:0]          div_val,
    output logic [NPORT-1:0]         port_en,
    output logic [NPORT*MAXB-1:0]    out_bank,
    output logic                     irq
);

    localparam int BW = $clog2(MAXB);
    localparam int NB = NPORT * MAXB;

    typedef struct packed {
        logic [BW-1:0]    bpp;
        logic [DIVW-1:0]  div;
        logic [NPORT-1:0] pen;
        logic [NB-1:0]    outb;
        logic [NB-1:0]    ie;
        logic [NB-1:0]    flg;
        logic [NB-1:0]    inh;
    } reg_t;

    reg_t          r_d, r_q;
    logic [NB-1:0] clr;
    logic          flg_wr;

    always_comb begin
        r_d    = r_q;
        clr    = '0;
        flg_wr = 1'b0;
        if (host_wr) begin
            if (host_addr == REG_CFG) r_d.bpp = host_wdata[BW-1:0];
            if (host_addr == REG_DIV) r_d.div = host_wdata[DIVW-1:0];
            if (host_addr == REG_PEN) r_d.pen = host_wdata[NPORT-1:0];
            for (int b = 0; b < MAXB; b++) begin
                if (host_addr == REG_OUT0 + ADDR_W'(b))
                    r_d.outb[b*NPORT +: NPORT] = host_wdata[NPORT-1:0];
                if (host_addr == REG_IE0 + ADDR_W'(b))
                    r_d.ie[b*NPORT +: NPORT] = host_wdata[NPORT-1:0];
                if (host_addr == REG_FLG0 + ADDR_W'(b)) begin
                    clr[b*NPORT +: NPORT] = host_wdata[NPORT-1:0];
                    flg_wr                = 1'b1;
                end
            end
        end
        r_d.flg = (r_q.flg & ~clr) | (commit ? (cap_data ^ r_q.inh) : '0);
        if (commit) r_d.inh = cap_data;
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == REG_CFG) host_rdata[BW-1:0]    = r_q.bpp;
        if (host_addr == REG_DIV) host_rdata[DIVW-1:0]  = r_q.div;
        if (host_addr == REG_PEN) host_rdata[NPORT-1:0] = r_q.pen;
        for (int b = 0; b < MAXB; b++) begin
            if (host_addr == REG_OUT0 + ADDR_W'(b)) host_rdata[NPORT-1:0] = r_q.outb[b*NPORT +: NPORT];
            if (host_addr == REG_IN0  + ADDR_W'(b)) host_rdata[NPORT-1:0] = r_q.inh[b*NPORT +: NPORT];
            if (host_addr == REG_IE0  + ADDR_W'(b)) host_rdata[NPORT-1:0] = r_q.ie[b*NPORT +: NPORT];
            if (host_addr == REG_FLG0 + ADDR_W'(b)) host_rdata[NPORT-1:0] = r_q.flg[b*NPORT +: NPORT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.div <= DIVW'(DIV_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign bpp_m1   = r_q.bpp;
    assign div_val  = r_q.div;
    assign port_en  = r_q.pen;
    assign out_bank = r_q.outb;
    assign irq      = |(r_q.flg & r_q.ie);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && flg_wr) |=> ((r_q.flg & $past(r_q.flg)) == $past(r_q.flg))) else $error("flag lost without clear"); // R8

    AST_IN_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(r_q.inh)) else $error("input bank moved outside latch"); // R7

endmodule

// File: rtl/sio_expander.sv
`timescale 1ns/1ps
module sio_expander
    import sio_pkg::*;
#(
    parameter int NPORT   = 32,
    parameter int MAXB    = 4,
    parameter int DIVW    = 16,
    parameter int DIV_RST = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                ser_clk,
    output logic                ser_dout,
    output logic                ser_load,
    input  logic                ser_din,
    output logic                irq
);

    localparam int BW = $clog2(MAXB);
    localparam int NB = NPORT * MAXB;

    logic [BW-1:0]    bpp_m1;
    logic [DIVW-1:0]  div_cfg;
    logic [DIVW-1:0]  div_use;
    logic [NPORT-1:0] port_en;
    logic [NB-1:0]    out_bank;
    logic [NB-1:0]    cap_data;
    logic             commit;
    logic             run;
    logic             tick;

    sio_host_regs #(
        .NPORT(NPORT), .MAXB(MAXB), .DIVW(DIVW), .DIV_RST(DIV_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .commit(commit), .cap_data(cap_data),
        .bpp_m1(bpp_m1), .div_val(div_cfg), .port_en(port_en),
        .out_bank(out_bank), .irq(irq)
    );

    sio_clkdiv #(.DIVW(DIVW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div_val(div_use), .tick(tick)
    );

    sio_frame_seq #(.NPORT(NPORT), .MAXB(MAXB), .DIVW(DIVW)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .port_en(port_en), .bpp_m1(bpp_m1), .div_cfg(div_cfg),
        .out_bank(out_bank), .sdin(ser_din),
        .run(run), .div_use(div_use),
        .sclk(ser_clk), .sdout(ser_dout), .sload(ser_load),
        .commit(commit), .cap_data(cap_data)
    );

endmodule

// File: tb/sim_sio_expander.sv
`timescale 1ns/1ps
module sim_sio_expander;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        ser_clk, ser_dout, ser_load, irq;
    logic        ser_din = 1'b0;

    int tests = 0;
    int fails = 0;

    logic [127:0] out_model;
    logic [127:0] in_pat;
    logic [31:0]  cur_en;
    int           cur_bpp;
    int           seq_p[128];
    int           seq_b[128];
    int           seq_n;

    logic rec[256];
    logic last[256];
    logic drive[256];
    int   nb = 0, last_nb = 0, frames = 0, edges = 0;
    int   hi_cnt = 0, hi_last = 0, ld_cnt = 0, ld_last = 0, ld_clk_err = 0;
    logic pclk = 1'b0, pld = 1'b0;

    always #10 clk = ~clk;

    sio_expander u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_load(ser_load),
        .ser_din(ser_din), .irq(irq)
    );

    // Pin monitor and external chain model, sampling 5 ns after each edge
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            if (ser_clk && !pclk) begin
                rec[nb] = ser_dout;
                if (nb < 255) nb++;
                edges++;
            end
            if (!ser_clk && pclk) hi_last = hi_cnt;
            if (ser_clk) hi_cnt = pclk ? hi_cnt + 1 : 1;
            if (ser_load && ser_clk) ld_clk_err++;
            if (ser_load && !pld) begin
                for (int i = 0; i < 256; i++) last[i] = rec[i];
                last_nb = nb;
                nb = 0;
                frames++;
            end
            if (!ser_load && pld) ld_last = ld_cnt;
            if (ser_load) ld_cnt = pld ? ld_cnt + 1 : 1;
            ser_din = drive[nb];
            pclk = ser_clk;
            pld  = ser_load;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic wait_frames(input int n);
        int target;
        target = frames + n;
        while (frames < target) @(negedge clk);
    endtask

    task automatic wait_bits(input int k);
        while (nb < k) @(negedge clk);
    endtask

    task automatic build_seq();
        seq_n = 0;
        for (int p = 0; p < 32; p++)
            for (int b = 0; b < cur_bpp; b++)
                if (cur_en[p]) begin
                    seq_p[seq_n] = p; seq_b[seq_n] = b; seq_n++;
                end
        for (int i = 0; i < 256; i++)
            drive[i] = (i < seq_n) ? in_pat[seq_b[i]*32 + seq_p[i]] : 1'b0;
    endtask

    task automatic set_cfg(input logic [31:0] en, input int bpp);
        cur_en = en; cur_bpp = bpp;
        build_seq();
        wr(5'd0, 32'(bpp - 1));
        wr(5'd2, en);
    endtask

    task automatic write_out(input logic [127:0] v);
        for (int b = 0; b < 4; b++) wr(5'd4 + 5'(b), v[b*32 +: 32]);
    endtask

    task automatic chk_frame(input logic [127:0] ov, input string req);
        int bad, first_bad;
        bad = 0; first_bad = -1;
        chk(last_nb == seq_n, "R3", "bits per frame", 32'(last_nb), 32'(seq_n));
        for (int i = 0; i < seq_n; i++)
            if (last[i] !== ov[seq_b[i]*32 + seq_p[i]]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        chk(bad == 0, req, "frame bits (mismatches / first index)", 32'(bad), 32'(first_bad));
    endtask

    function automatic logic [31:0] exp_in_word(input int b);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < seq_n; i++)
            if (seq_b[i] == b) w[seq_p[i]] = in_pat[b*32 + seq_p[i]];
        return w;
    endfunction

    // R1, R9: reset values and idle with no enabled port
    task automatic t_reset();
        logic [31:0] v;
        chk(ser_clk == 1'b0 && ser_load == 1'b0 && ser_dout == 1'b0, "R1", "pins after reset",
            {29'd0, ser_clk, ser_load, ser_dout}, 32'd0);
        chk(irq == 1'b0, "R1", "irq after reset", 32'(irq), 32'd0);
        rd(5'd1, v);  chk(v == 32'd2, "R1", "DIV reset", v, 32'd2);
        rd(5'd0, v);  chk(v == 32'd0, "R1", "CFG reset", v, 32'd0);
        rd(5'd2, v);  chk(v == 32'd0, "R1", "PORT_EN reset", v, 32'd0);
        rd(5'd4, v);  chk(v == 32'd0, "R1", "OUT0 reset", v, 32'd0);
        rd(5'd11, v); chk(v == 32'd0, "R1", "IN3 reset", v, 32'd0);
        rd(5'd16, v); chk(v == 32'd0, "R1", "FLAG0 reset", v, 32'd0);
        repeat (60) @(negedge clk);
        chk(edges == 0, "R9", "edges while no port enabled", 32'(edges), 32'd0);
    endtask

    // R2, R3, R10: four bits per port on a sparse mask
    task automatic t_basic();
        out_model = 128'h9A3C_5F01_E2D4_7B68_0C91_F3A5_4E27_D6B8;
        write_out(out_model);
        set_cfg(32'h8007_0001, 4);
        wait_frames(2);
        chk_frame(out_model, "R2");
    endtask

    // R10, R3: one and two bits per port
    task automatic t_bpp();
        set_cfg(32'hF0F0_00FF, 1);
        wait_frames(2);
        chk_frame(out_model, "R10");
        set_cfg(32'hF0F0_00FF, 2);
        wait_frames(2);
        chk_frame(out_model, "R10");
    endtask

    // R4, R5: half-period and latch length
    task automatic t_timing();
        wr(5'd1, 32'd3);
        wait_frames(3);
        chk(hi_last == 3, "R4", "high phase at DIV=3", 32'(hi_last), 32'd3);
        chk(ld_last == 6, "R5", "latch length at DIV=3", 32'(ld_last), 32'd6);
        wr(5'd1, 32'd0);
        wait_frames(3);
        chk(hi_last == 1, "R4", "high phase at DIV=0", 32'(hi_last), 32'd1);
        chk(ld_last == 2, "R5", "latch length at DIV=0", 32'(ld_last), 32'd2);
        wr(5'd1, 32'd2);
        wait_frames(3);
        chk(hi_last == 2, "R4", "high phase at DIV=2", 32'(hi_last), 32'd2);
        chk(ld_clk_err == 0, "R5", "ser_clk high during latch", 32'(ld_clk_err), 32'd0);
    endtask

    // R6: mid-frame write lands in the next frame
    task automatic t_snapshot();
        logic [127:0] old_v, new_v;
        old_v = out_model;
        new_v = ~out_model ^ 128'h0F0F_0000_FFFF_1234_0000_0000_AAAA_5555;
        wait_frames(1);
        wait_bits(3);
        write_out(new_v);
        out_model = new_v;
        wait_frames(1);
        chk_frame(old_v, "R6");
        wait_frames(1);
        chk_frame(new_v, "R6");
    endtask

    // R7: capture into the IN bank and the all-at-once update
    task automatic t_input();
        logic [31:0] v;
        logic [127:0] pat_a;
        in_pat = 128'h1357_9BDF_2468_ACE0_FEDC_BA98_7654_3210;
        pat_a = in_pat;
        set_cfg(32'h0000_F00F, 2);
        wait_frames(3);
        wait_bits(1);
        rd(5'd8, v); chk(v == exp_in_word(0), "R7", "IN0 pattern A", v, exp_in_word(0));
        rd(5'd9, v); chk(v == exp_in_word(1), "R7", "IN1 pattern A", v, exp_in_word(1));
        rd(5'd10, v); chk(v == 32'd0, "R7", "IN2 unshifted index", v, 32'd0);
        wait_frames(1);
        in_pat = ~pat_a;
        build_seq();
        wait_bits(3);
        in_pat = pat_a;
        rd(5'd8, v); chk(v == exp_in_word(0), "R7", "IN0 unchanged mid-frame", v, exp_in_word(0));
        in_pat = ~pat_a;
        wait_frames(2);
        wait_bits(1);
        rd(5'd8, v); chk(v == exp_in_word(0), "R7", "IN0 pattern B", v, exp_in_word(0));
    endtask

    // R8: change flags, write-one-to-clear, interrupt gating
    task automatic t_irq();
        logic [31:0] v;
        wr(5'd16, 32'hFFFF_FFFF);
        wr(5'd17, 32'hFFFF_FFFF);
        wr(5'd18, 32'hFFFF_FFFF);
        wr(5'd19, 32'hFFFF_FFFF);
        wr(5'd12, 32'h0000_0001);
        rd(5'd16, v); chk(v == 32'd0, "R8", "FLAG0 after clear", v, 32'd0);
        chk(irq == 1'b0, "R8", "irq after clear", 32'(irq), 32'd0);
        in_pat[0]      = ~in_pat[0];
        in_pat[32+13]  = ~in_pat[32+13];
        build_seq();
        wait_frames(2);
        wait_bits(1);
        rd(5'd16, v); chk(v == 32'h0000_0001, "R8", "FLAG0 after change", v, 32'h1);
        rd(5'd17, v); chk(v == 32'h0000_2000, "R8", "FLAG1 after change", v, 32'h2000);
        chk(irq == 1'b1, "R8", "irq with enabled flag", 32'(irq), 32'd1);
        wr(5'd17, 32'h0000_0000);
        rd(5'd17, v); chk(v == 32'h0000_2000, "R8", "FLAG1 after writing zero", v, 32'h2000);
        wr(5'd16, 32'h0000_0001);
        @(negedge clk);
        chk(irq == 1'b0, "R8", "irq with only unenabled flag", 32'(irq), 32'd0);
    endtask

    // R9: clearing the mask mid-frame finishes the frame, then idles
    task automatic t_idle();
        int e0;
        wait_frames(1);
        wait_bits(2);
        wr(5'd2, 32'd0);
        wait_frames(1);
        chk(last_nb == seq_n, "R9", "frame completed after disable", 32'(last_nb), 32'(seq_n));
        repeat (10) @(negedge clk);
        e0 = edges;
        repeat (300) @(negedge clk);
        chk(edges == e0, "R9", "edges while idle", 32'(edges - e0), 32'd0);
        chk(ser_load == 1'b0 && ser_dout == 1'b0 && ser_clk == 1'b0, "R9", "pins while idle",
            {29'd0, ser_clk, ser_load, ser_dout}, 32'd0);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        out_model = '0;
        in_pat    = '0;
        cur_en    = '0;
        cur_bpp   = 1;
        for (int i = 0; i < 256; i++) begin
            rec[i] = 1'b0; last[i] = 1'b0; drive[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_bpp();
        t_timing();
        t_snapshot();
        t_input();
        t_irq();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule